// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This unit multiplies two signed fractional operands of `W` bits each and doubles the product, so that the binary point of a Q(W-1) by Q(W-1) multiply lands on a Q(2W-1) result. It then adds that product to a `2W`-bit accumulator value, or subtracts it, and saturates the result. One corner case cannot be represented after doubling: when both operands are the most negative value, the doubled product would be +1.0. In that case the product is clamped to the largest positive value and a multiply-overflow condition is raised. The add or subtract that follows saturates to the largest positive or the most negative accumulator value whenever the exact sum is out of range.

The pipeline has one register stage. Operands and the add/subtract select are captured at a clock edge. In the following cycle the caller presents the matching accumulator value, and the result and overflow flag are available combinationally in that same cycle. This allows the accumulator to come from a forwarding path that is resolved late. A new operation can be issued every cycle. Two adders run in parallel in the second stage: one works on the doubled product and one on the clamped product. A three-way select then picks the exact sum, the sum with the clamped product, or a saturation constant. Subtraction feeds the inverted product to the adder with a carry-in of one.

Top module: `frac_mac`

## Requirements
- R1: With `op_sub`=0 and no overflow, `result` equals `acc + 2*opa*opb`, read as signed values, and `ovf` is 0.
- R2: When `opa` and `opb` are both -2^(W-1), the product is replaced by 2^(2W-1)-1 and `ovf` is 1 for that operation, whatever the accumulator is.
- R3: With `op_sub`=1 and no overflow, `result` equals `acc - 2*opa*opb` and `ovf` is 0.
- R4: When the exact sum or difference is above 2^(2W-1)-1, `result` is 2^(2W-1)-1 (MSB 0, all other bits 1). When it is below -2^(2W-1), `result` is -2^(2W-1) (MSB 1, all other bits 0). In both cases `ovf` is 1.
- R5: When the product is clamped (R2) and `acc` plus or minus the clamped product fits in 2W bits, `result` equals that exact value and `ovf` is still 1.
- R6: Operands, `op_sub` and `in_valid` are sampled at a rising edge. `out_valid` is high for the whole next cycle. In that cycle `result` and `ovf` follow the `acc` present at that time combinationally. Issuing on every cycle gives one result per cycle.
- R7: While `rst_n` is low, and afterwards until the first issued operation, `out_valid` is 0.
- R8: A cycle with `in_valid`=0 leaves the captured product and `op_sub` unchanged. In the next cycle `out_valid` is 0, and `result` still reflects the previously captured operation combined with the current `acc`.
- R9: If either operand is zero, `result` equals `acc` and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with `clk` |
| in_valid | input | 1 | Issue an operation this cycle |
| op_sub | input | 1 | 1 = subtract the product from the accumulator, 0 = add |
| opa | input | W | Signed fractional operand A |
| opb | input | W | Signed fractional operand B |
| acc | input | 2W | Signed accumulator value, presented one cycle after its operands |
| out_valid | output | 1 | A result for an issued operation is present |
| result | output | 2W | Saturated signed result |
| ovf | output | 1 | Overflow of the current operation (product clamp or sum saturation) |

## Verification
The bench builds two instances. The first uses `W`=4 (an 8-bit accumulator) and is swept over every operand pair, both operations, and sixteen accumulator values that span the full range from the most negative to the most positive. At this size every clamped product, every saturation direction and every boundary sum can be reached exhaustively. The second instance uses the default `W`=16. It exercises the same corners at full width: both operands most negative with various accumulators, and accumulators at positive and negative full scale. It also runs random operands and a held-product cycle, with expected values computed arithmetically.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;

  // result source picked in stage 2
  typedef enum logic [1:0] {
    SRC_EXACT    = 2'd0,
    SRC_SATPROD  = 2'd1,
    SRC_CLAMP_HI = 2'd2,
    SRC_CLAMP_LO = 2'd3
  } fm_src_e;

  // two's-complement overflow of x + y (+cin): equal operand signs, sum sign differs
  function automatic logic add_ovf(input logic sx, input logic sy, input logic ss);
    return (sx == sy) && (ss != sx);
  endfunction

endpackage

// File: rtl/fm_prod.sv
module fm_prod #(
  parameter int W = 16
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           op_sub,
  output logic [2*W-1:0] prod_op,
  output logic           mul_ovf
);
  localparam int AW = 2 * W;
  localparam logic [AW-1:0] OVF_PAT = {2'b01, {(AW-2){1'b0}}};

  logic signed [AW-1:0] ext_a;
  logic signed [AW-1:0] ext_b;
  logic signed [AW-1:0] raw;
  logic [AW-1:0]        dbl;

  always_comb begin
    ext_a   = {{W{opa[W-1]}}, opa};
    ext_b   = {{W{opb[W-1]}}, opb};
    raw     = ext_a * ext_b;
    mul_ovf = (raw == OVF_PAT);
    dbl     = {raw[AW-2:0], 1'b0};
    prod_op = op_sub ? ~dbl : dbl;
  end

endmodule

// File: rtl/fm_pipe.sv
module fm_pipe #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] d_op,
  input  logic          d_movf,
  input  logic          d_sub,
  output logic          q_valid,
  output logic [AW-1:0] q_op,
  output logic          q_movf,
  output logic          q_sub
);
  logic          valid_nxt;
  logic [AW-1:0] op_nxt;
  logic          movf_nxt;
  logic          sub_nxt;

  always_comb begin
    valid_nxt = in_valid;
    op_nxt    = q_op;
    movf_nxt  = q_movf;
    sub_nxt   = q_sub;
    if (in_valid) begin
      op_nxt   = d_op;
      movf_nxt = d_movf;
      sub_nxt  = d_sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_op    <= '0;
      q_movf  <= 1'b0;
      q_sub   <= 1'b0;
    end else begin
      q_valid <= valid_nxt;
      q_op    <= op_nxt;
      q_movf  <= movf_nxt;
      q_sub   <= sub_nxt;
    end
  end

endmodule

// File: rtl/fm_adder.sv
module fm_adder
  import frac_mac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic          cin,
  output logic [AW-1:0] sum,
  output logic          ovf
);
  always_comb begin
    sum = x + y + {{(AW-1){1'b0}}, cin};
    ovf = add_ovf(x[AW-1], y[AW-1], sum[AW-1]);
  end

endmodule

// File: rtl/fm_select.sv
module fm_select
  import frac_mac_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          mul_ovf,
  input  logic [AW-1:0] sum_exact,
  input  logic          ovf_exact,
  input  logic [AW-1:0] sum_sat,
  input  logic          ovf_sat,
  input  logic          acc_neg,
  output logic [AW-1:0] result,
  output logic          ovf
);
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV = {1'b1, {(AW-1){1'b0}}};

  fm_src_e src;

  always_comb begin
    ovf = mul_ovf | ovf_exact;
    if (!ovf)                   src = SRC_EXACT;
    else if (mul_ovf && !ovf_sat) src = SRC_SATPROD;
    else if (!acc_neg)          src = SRC_CLAMP_HI;
    else                        src = SRC_CLAMP_LO;

    case (src)
      SRC_EXACT:    result = sum_exact;
      SRC_SATPROD:  result = sum_sat;
      SRC_CLAMP_HI: result = MAXV;
      default:      result = MINV;
    endcase
  end

endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic [2*W-1:0]   acc,
  output logic             out_valid,
  output logic [2*W-1:0]   result,
  output logic             ovf
);
  localparam int AW     = 2 * W;
  localparam int N_ADD  = 2;
  localparam logic [AW-1:0] MAXV = {1'b0, {(AW-1){1'b1}}};

  logic [AW-1:0] s1_op;
  logic          s1_movf;
  logic [AW-1:0] q_op;
  logic          q_movf;
  logic          q_sub;

  logic [AW-1:0] add_y   [N_ADD];
  logic [AW-1:0] add_sum [N_ADD];
  logic          add_of  [N_ADD];

  fm_prod #(.W(W)) u_prod (
    .opa     (opa),
    .opb     (opb),
    .op_sub  (op_sub),
    .prod_op (s1_op),
    .mul_ovf (s1_movf)
  );

  fm_pipe #(.AW(AW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .d_op     (s1_op),
    .d_movf   (s1_movf),
    .d_sub    (op_sub),
    .q_valid  (out_valid),
    .q_op     (q_op),
    .q_movf   (q_movf),
    .q_sub    (q_sub)
  );

  // lane 0: doubled product, lane 1: clamped product
  assign add_y[0] = q_op;
  assign add_y[1] = q_sub ? ~MAXV : MAXV;

  for (genvar k = 0; k < N_ADD; k++) begin : g_add
    fm_adder #(.AW(AW)) u_add (
      .x   (acc),
      .y   (add_y[k]),
      .cin (q_sub),
      .sum (add_sum[k]),
      .ovf (add_of[k])
    );
  end

  fm_select #(.AW(AW)) u_sel (
    .mul_ovf   (q_movf),
    .sum_exact (add_sum[0]),
    .ovf_exact (add_of[0]),
    .sum_sat   (add_sum[1]),
    .ovf_sat   (add_of[1]),
    .acc_neg   (acc[AW-1]),
    .result    (result),
    .ovf       (ovf)
  );

endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           op_sub,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic [2*W-1:0] acc,
  input logic           out_valid,
  input logic [2*W-1:0] result,
  input logic           ovf
);
  localparam int AW = 2 * W;
  localparam logic [W-1:0]  MIN_OP = {1'b1, {(W-1){1'b0}}};
  localparam logic [AW-1:0] MAXV   = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV   = {1'b1, {(AW-1){1'b0}}};

  // R6
  valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R2
  mul_sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && $past(in_valid && opa == MIN_OP && opb == MIN_OP)) |-> ovf);

  // R9
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && $past(in_valid && (opa == '0 || opb == '0)))
      |-> (result == acc && !ovf));

  // R4
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && ovf && !$past(opa == MIN_OP && opb == MIN_OP))
      |-> (result == MAXV || result == MINV));

endmodule

bind frac_mac frac_mac_chk #(.W(W)) u_frac_mac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sub    (op_sub),
  .opa       (opa),
  .opb       (opb),
  .acc       (acc),
  .out_valid (out_valid),
  .result    (result),
  .ovf       (ovf)
);

// File: tb/test_frac_mac.sv
`timescale 1ns/1ps
module test_frac_mac;

  logic clk;
  logic rst_n;
  int   n_cmp;
  int   n_bad;
  bit   done;

  // default-width instance
  logic        b_vld, b_sub;
  logic [15:0] b_opa, b_opb;
  logic [31:0] b_acc;
  logic        b_ovld, b_ovf;
  logic [31:0] b_res;

  // small instance, W = 4
  logic        s_vld, s_sub;
  logic [3:0]  s_opa, s_opb;
  logic [7:0]  s_acc;
  logic        s_ovld, s_ovf;
  logic [7:0]  s_res;

  frac_mac i_frac_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(b_vld), .op_sub(b_sub),
    .opa(b_opa), .opb(b_opb), .acc(b_acc),
    .out_valid(b_ovld), .result(b_res), .ovf(b_ovf)
  );

  frac_mac #(.W(4)) i_frac_mac_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_vld), .op_sub(s_sub),
    .opa(s_opa), .opb(s_opb), .acc(s_acc),
    .out_valid(s_ovld), .result(s_res), .ovf(s_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_model(input int w, input longint a, input longint b,
                                    input longint acc, input bit sub,
                                    output longint res, output bit ovf,
                                    output bit movf, output bit clamp);
    longint maxv, minv, p, s;
    maxv  = (longint'(1) <<< (2*w-1)) - 1;
    minv  = -maxv - 1;
    p     = a * b;
    movf  = (p == (longint'(1) <<< (2*w-2)));
    p     = movf ? maxv : 2 * p;
    s     = sub ? acc - p : acc + p;
    clamp = 1'b0;
    if (s > maxv) begin s = maxv; clamp = 1'b1; end
    else if (s < minv) begin s = minv; clamp = 1'b1; end
    res = s;
    ovf = movf | clamp;
  endfunction

  function automatic string tag_of(input longint a, input longint b, input bit sub,
                                   input bit movf, input bit clamp);
    if (movf)                return clamp ? "R2" : "R5";
    if (clamp)               return "R4";
    if (a == 0 || b == 0)    return "R9";
    return sub ? "R3" : "R1";
  endfunction

  // pending operation per instance: operands issued, acc still to be driven
  bit     bp_have, sp_have;
  longint bp_a, bp_b, bp_acc, sp_a, sp_b, sp_acc;
  bit     bp_sub, sp_sub;

  task automatic check_op(input int w, input longint a, input longint b, input longint acc,
                          input bit sub, input longint got, input bit gov, input bit gvld);
    longint er;
    bit eo, mv, cl;
    string  t;
    ref_model(w, a, b, acc, sub, er, eo, mv, cl);
    t = tag_of(a, b, sub, mv, cl);
    chk(t, "result", got, er);
    chk(t, "ovf", longint'(gov), longint'(eo));
    chk("R6", "out_valid", longint'(gvld), 1);
  endtask

  task automatic big_step(input bit vld, input longint a, input longint b,
                          input bit sub, input longint acc);
    @(negedge clk);
    b_acc = bp_have ? bp_acc[31:0] : 32'd0;
    b_vld = vld;
    b_opa = a[15:0];
    b_opb = b[15:0];
    b_sub = sub;
    #1;
    if (bp_have)
      check_op(16, bp_a, bp_b, bp_acc, bp_sub, longint'($signed(b_res)), b_ovf, b_ovld);
    bp_have = vld;
    bp_a = a; bp_b = b; bp_sub = sub; bp_acc = acc;
  endtask

  task automatic small_step(input bit vld, input longint a, input longint b,
                            input bit sub, input longint acc);
    @(negedge clk);
    s_acc = sp_have ? sp_acc[7:0] : 8'd0;
    s_vld = vld;
    s_opa = a[3:0];
    s_opb = b[3:0];
    s_sub = sub;
    #1;
    if (sp_have)
      check_op(4, sp_a, sp_b, sp_acc, sp_sub, longint'($signed(s_res)), s_ovf, s_ovld);
    sp_have = vld;
    sp_a = a; sp_b = b; sp_sub = sub; sp_acc = acc;
  endtask

  localparam longint BMAX = 64'sd2147483647;
  localparam longint BMIN = -64'sd2147483648;

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    bp_have = 1'b0; sp_have = 1'b0;
    rst_n = 1'b0;
    b_vld = 1'b0; b_sub = 1'b0; b_opa = '0; b_opb = '0; b_acc = '0;
    s_vld = 1'b0; s_sub = 1'b0; s_opa = '0; s_opb = '0; s_acc = '0;
    repeat (3) @(negedge clk);
    // R7: no valid output while in reset
    chk("R7", "out_valid big in reset", longint'(b_ovld), 0);
    chk("R7", "out_valid small in reset", longint'(s_ovld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R7", "out_valid big after reset", longint'(b_ovld), 0);
    chk("R7", "out_valid small after reset", longint'(s_ovld), 0);

    // full-width corners: R2, R5, R4 at both full scales
    big_step(1, -32768, -32768, 0, 0);           // R5: MAX, ovf
    big_step(1, -32768, -32768, 0, 1);           // R2: clamp high
    big_step(1, -32768, -32768, 1, 0);           // R5: -MAX
    big_step(1, -32768, -32768, 1, -1);          // R5: exactly MIN
    big_step(1, -32768, -32768, 1, -2);          // R2: clamp low
    big_step(1, -32768, -32768, 0, BMIN);        // R5: -1
    big_step(1, 1, 1, 0, BMAX);                  // R4 positive full scale
    big_step(1, 1, 1, 1, BMIN);                  // R4 negative full scale
    big_step(1, 1, 1, 1, BMAX);                  // R3 just below
    big_step(1, -1, 1, 0, BMIN + 2);             // R1 near bottom
    big_step(1, 32767, 32767, 0, BMAX);          // R4
    big_step(1, 32767, -32768, 1, BMAX);         // R4 via subtract
    big_step(1, 0, -32768, 1, BMIN);             // R9
    big_step(1, 12345, 0, 0, BMAX);              // R9
    // back-to-back random traffic, R1/R3/R6
    for (int i = 0; i < 2000; i++) begin
      longint ra, rb, rc;
      ra = longint'($signed(16'($urandom)));
      rb = longint'($signed(16'($urandom)));
      rc = longint'($signed(32'($urandom)));
      if (i % 7 == 0) rc = (i % 2 == 0) ? BMAX - longint'($urandom_range(0, 3)) : BMIN + longint'($urandom_range(0, 3));
      big_step(1, ra, rb, i[0], rc);
    end
    // R8: an idle cycle keeps the captured product
    big_step(1, 3, 5, 0, 7);
    big_step(0, 100, 100, 1, 0);   // drives acc for 3*5, checks it
    @(negedge clk);
    b_acc = 32'd10;
    b_opa = 16'd77;
    #1;
    chk("R8", "held result", longint'($signed(b_res)), 40);
    chk("R8", "held ovf", longint'(b_ovf), 0);
    chk("R6", "out_valid after idle", longint'(b_ovld), 0);

    // small configuration: every operand pair, both ops, 16 accumulators
    for (int k = 0; k < 16; k++) begin
      for (int sub = 0; sub < 2; sub++) begin
        for (int a = -8; a < 8; a++) begin
          for (int b = -8; b < 8; b++) begin
            small_step(1, longint'(a), longint'(b), sub[0], longint'(k * 17 - 128));
          end
        end
      end
    end
    small_step(0, 0, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule